// File: doc/BRIEF.md
# Boot load sequencer

This block runs the load-normal bring-up flow once a load command is taken. It first works through a set number of built-in diagnostic tests and pulses the system reset before each one. If every test passes, it pulses the system reset once more. It then writes zero to every memory word through a one-word-per-cycle write port. Next it copies a diagnostic image and then a small bootstrap loader into two fixed address windows.

When loading is done, the block raises run mode. It starts the processor at the diagnostic entry point. If the processor reports that the diagnostic program passed, the block restarts it at the bootstrap entry point. If the program failed, the block signals that the processor must wait. A test failure or a load failure ends the flow early with a coded error event. A test failure also returns the status word that names the failing element. The test engine, the image source and the processor are outside the block and are reached through simple handshake pins.

Top module: `boot_load_seq`

## Requirements
- R1: A load command is taken only in a cycle where `load_req` and `sys_idle` are both high and the block is idle. Otherwise it is ignored: `busy` stays low and no reset, test start or memory write appears.
- R2: `sys_reset` is a one-cycle pulse in the cycle after acceptance, and again after each passed test except the last. It is followed in the next cycle by a one-cycle `test_start` with `test_idx` counting 0, 1, … NUM_TESTS-1. A full pass gives exactly NUM_TESTS+1 reset pulses.
- R3: A `test_done` with `test_pass` low stops the flow. The next cycle shows `err_valid` with `err_code` = 0xF9 and `err_status` equal to the `test_status` given with that `test_done`. No memory write follows. `err_code`/`err_status` keep their values until the next error.
- R4: After the last passed test and one further reset pulse, every address from 0 to MEM_DEPTH-1 is written with zero, in ascending order.
- R5: Next, addresses 0x100..0x1FF are written with `img_data` while `img_sel` = 0 (diagnostic image). Then addresses 0x20..0x29 are written with `img_data` while `img_sel` = 1 (bootstrap loader).
- R6: If `img_err` is high on an accepted image write, the flow stops. The next cycle shows `err_valid` with `err_code` = 0xF0 and `err_status` = 0, and the processor is never started.
- R7: In the cycle after the final image write, `run_mode` rises and `cpu_start` pulses with `cpu_start_addr` = 0x160. `run_mode` stays high until the next accepted command.
- R8: A `cpu_diag_done` with `cpu_diag_ok` high gives, in the next cycle, a `cpu_start` pulse at 0x26, and `done` follows one cycle later. With `cpu_diag_ok` low, the next cycle shows `cpu_wait` and `done` together, with no second start.
- R9: `busy` is high from the cycle after acceptance until the flow ends. `done` and `err_valid` are one-cycle pulses that never coincide and appear with `busy` low.
- R10: A memory write advances only in a cycle where `mem_wready` is high. While `mem_we` is high and `mem_wready` low, `mem_addr` and `mem_we` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_req | input | 1 | Load command request |
| sys_idle | input | 1 | System is in its idle state |
| test_done | input | 1 | Current diagnostic test finished |
| test_pass | input | 1 | Test result, valid with test_done |
| test_status | input | STAT_W | Status word naming the failing element |
| mem_wready | input | 1 | Memory accepts the current write |
| img_data | input | DW | Image word for the current address and img_sel |
| img_err | input | 1 | Image source fault on the current word |
| cpu_diag_done | input | 1 | Processor finished the diagnostic program |
| cpu_diag_ok | input | 1 | Diagnostic program passed |
| busy | output | 1 | Flow in progress |
| sys_reset | output | 1 | System reset pulse |
| test_start | output | 1 | Start pulse for one diagnostic test |
| test_idx | output | TIDX_W | Number of the test being started |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| img_sel | output | 1 | 0 = diagnostic image, 1 = bootstrap loader |
| run_mode | output | 1 | System placed in run mode |
| cpu_start | output | 1 | Processor start pulse |
| cpu_start_addr | output | AW | Processor start address |
| done | output | 1 | Flow ended without load or test error |
| cpu_wait | output | 1 | Processor must enter its wait state |
| err_valid | output | 1 | Error event pulse |
| err_code | output | 8 | Error event code |
| err_status | output | STAT_W | Captured failing-element status |

## Verification
The embedded assertions watch several rules on every cycle. They check that `busy` rises only after a qualified command, and that each error code follows the input event that justifies it. They also check that a bootstrap start follows a passed diagnostic program, that `done` and `err_valid` never overlap, and that a stalled write holds its address. What only the bench's scenarios show is the ordering and content of the whole flow. That covers the reset count and the test numbering, the zeroed memory outside the windows, the image words landing in the right window, `run_mode` persisting and clearing, and the two endings of the processor stage. These are compared against a behavioural model with ready stalls, early test failure and a mid-window load fault.

// File: rtl/bls_pkg.sv
package bls_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_TRST,
      S_TGO,
      S_TWAIT,
      S_FRST,
      S_CLR,
      S_LDIAG,
      S_LBOOT,
      S_RUN,
      S_PWAIT,
      S_BOOT
   } bls_state_e;

   localparam logic [7:0] EVT_TEST_FAIL = 8'hF9;
   localparam logic [7:0] EVT_LOAD_FAIL = 8'hF0;

endpackage

// File: rtl/bls_test_ctr.sv
module bls_test_ctr #(
   parameter int unsigned N = 4,
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] idx,
   output logic         last
);

   generate
      if (N == 1) begin : g_single
         logic unused_ctl;
         assign unused_ctl = clr ^ inc;
         assign idx  = '0;
         assign last = 1'b1;
      end else begin : g_multi
         localparam logic [W-1:0] LAST_IDX = W'(N - 1);
         logic [W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt_q <= '0;
            else if (clr) cnt_q <= '0;
            else if (inc) cnt_q <= cnt_q + 1'b1;
         end
         assign idx  = cnt_q;
         assign last = (cnt_q == LAST_IDX);
      end
   endgenerate

endmodule

// File: rtl/bls_addr_gen.sv
module bls_addr_gen #(
   parameter int unsigned AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          inc,
   output logic [AW-1:0] addr
);

   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (load) addr_q <= load_val;
      else if (inc)  addr_q <= addr_q + 1'b1;
   end

   assign addr = addr_q;

endmodule

// File: rtl/bls_event_reg.sv
module bls_event_reg #(
   parameter int unsigned STAT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_done,
   input  logic              fire_wait,
   input  logic              fire_err,
   input  logic [7:0]        code_in,
   input  logic              cap_stat,
   input  logic [STAT_W-1:0] stat_in,
   output logic              done,
   output logic              cpu_wait,
   output logic              err_valid,
   output logic [7:0]        err_code,
   output logic [STAT_W-1:0] err_status
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done       <= 1'b0;
         cpu_wait   <= 1'b0;
         err_valid  <= 1'b0;
         err_code   <= '0;
         err_status <= '0;
      end else begin
         done      <= fire_done;
         cpu_wait  <= fire_wait;
         err_valid <= fire_err;
         if (fire_err) begin
            err_code   <= code_in;
            err_status <= cap_stat ? stat_in : '0;
         end
      end
   end

endmodule

// File: rtl/boot_load_seq.sv
module boot_load_seq
   import bls_pkg::*;
#(
   parameter int unsigned NUM_TESTS  = 4,
   parameter int unsigned AW         = 12,
   parameter int unsigned DW         = 32,
   parameter int unsigned STAT_W     = 16,
   parameter int unsigned MEM_DEPTH  = 1024,
   parameter int unsigned DIAG_LO    = 'h100,
   parameter int unsigned DIAG_HI    = 'h1FF,
   parameter int unsigned BOOT_LO    = 'h20,
   parameter int unsigned BOOT_HI    = 'h29,
   parameter int unsigned DIAG_ENTRY = 'h160,
   parameter int unsigned BOOT_ENTRY = 'h26,
   // derived: width of the test number
   parameter int unsigned TIDX_W     = (NUM_TESTS > 1) ? $clog2(NUM_TESTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_req,
   input  logic              sys_idle,
   input  logic              test_done,
   input  logic              test_pass,
   input  logic [STAT_W-1:0] test_status,
   input  logic              mem_wready,
   input  logic [DW-1:0]     img_data,
   input  logic              img_err,
   input  logic              cpu_diag_done,
   input  logic              cpu_diag_ok,
   output logic              busy,
   output logic              sys_reset,
   output logic              test_start,
   output logic [TIDX_W-1:0] test_idx,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   output logic              img_sel,
   output logic              run_mode,
   output logic              cpu_start,
   output logic [AW-1:0]     cpu_start_addr,
   output logic              done,
   output logic              cpu_wait,
   output logic              err_valid,
   output logic [7:0]        err_code,
   output logic [STAT_W-1:0] err_status
);

   localparam logic [AW-1:0] MEM_LAST  = AW'(MEM_DEPTH - 1);
   localparam logic [AW-1:0] DLO       = AW'(DIAG_LO);
   localparam logic [AW-1:0] DHI       = AW'(DIAG_HI);
   localparam logic [AW-1:0] BLO       = AW'(BOOT_LO);
   localparam logic [AW-1:0] BHI       = AW'(BOOT_HI);
   localparam logic [AW-1:0] ENTRY_D   = AW'(DIAG_ENTRY);
   localparam logic [AW-1:0] ENTRY_B   = AW'(BOOT_ENTRY);

   // elaboration-time parameter checks
   generate
      if (NUM_TESTS < 1) begin : g_chk_tests
         $error("NUM_TESTS must be at least 1");
      end
      if (MEM_DEPTH > (1 << AW) || MEM_DEPTH < 2) begin : g_chk_depth
         $error("MEM_DEPTH must fit the address width");
      end
      if (DIAG_HI >= MEM_DEPTH || BOOT_HI >= MEM_DEPTH) begin : g_chk_win
         $error("load windows must lie inside memory");
      end
      if (DIAG_LO > DIAG_HI || BOOT_LO > BOOT_HI) begin : g_chk_order
         $error("load window bounds reversed");
      end
      if ((1 << TIDX_W) < NUM_TESTS) begin : g_chk_tidx
         $error("TIDX_W too small for NUM_TESTS");
      end
   endgenerate

   bls_state_e st_q, st_d;

   logic          ctr_clr, ctr_inc, ctr_last;
   logic          a_load, a_inc;
   logic [AW-1:0] a_val, addr;
   logic          ev_done, ev_wait, ev_err, ev_cap;
   logic [7:0]    ev_code;
   logic          run_set, run_clr, run_q;

   bls_test_ctr #(.N(NUM_TESTS), .W(TIDX_W)) u_tctr (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (ctr_clr),
      .inc  (ctr_inc),
      .idx  (test_idx),
      .last (ctr_last)
   );

   bls_addr_gen #(.AW(AW)) u_agen (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (a_load),
      .load_val(a_val),
      .inc     (a_inc),
      .addr    (addr)
   );

   bls_event_reg #(.STAT_W(STAT_W)) u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire_done (ev_done),
      .fire_wait (ev_wait),
      .fire_err  (ev_err),
      .code_in   (ev_code),
      .cap_stat  (ev_cap),
      .stat_in   (test_status),
      .done      (done),
      .cpu_wait  (cpu_wait),
      .err_valid (err_valid),
      .err_code  (err_code),
      .err_status(err_status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= S_IDLE;
         run_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (run_clr)      run_q <= 1'b0;
         else if (run_set) run_q <= 1'b1;
      end
   end

   always_comb begin
      st_d    = st_q;
      ctr_clr = 1'b0;
      ctr_inc = 1'b0;
      a_load  = 1'b0;
      a_val   = '0;
      a_inc   = 1'b0;
      ev_done = 1'b0;
      ev_wait = 1'b0;
      ev_err  = 1'b0;
      ev_cap  = 1'b0;
      ev_code = EVT_LOAD_FAIL;
      run_set = 1'b0;
      run_clr = 1'b0;
      case (st_q)
         S_IDLE: begin
            if (load_req && sys_idle) begin
               st_d    = S_TRST;
               ctr_clr = 1'b1;
               run_clr = 1'b1;
            end
         end
         S_TRST: st_d = S_TGO;
         S_TGO:  st_d = S_TWAIT;
         S_TWAIT: begin
            if (test_done) begin
               if (!test_pass) begin
                  ev_err  = 1'b1;
                  ev_cap  = 1'b1;
                  ev_code = EVT_TEST_FAIL;
                  st_d    = S_IDLE;
               end else if (ctr_last) begin
                  st_d = S_FRST;
               end else begin
                  ctr_inc = 1'b1;
                  st_d    = S_TRST;
               end
            end
         end
         S_FRST: begin
            st_d   = S_CLR;
            a_load = 1'b1;
            a_val  = '0;
         end
         S_CLR: begin
            if (mem_wready) begin
               if (addr == MEM_LAST) begin
                  st_d   = S_LDIAG;
                  a_load = 1'b1;
                  a_val  = DLO;
               end else begin
                  a_inc = 1'b1;
               end
            end
         end
         S_LDIAG: begin
            if (mem_wready) begin
               if (img_err) begin
                  ev_err = 1'b1;
                  st_d   = S_IDLE;
               end else if (addr == DHI) begin
                  st_d   = S_LBOOT;
                  a_load = 1'b1;
                  a_val  = BLO;
               end else begin
                  a_inc = 1'b1;
               end
            end
         end
         S_LBOOT: begin
            if (mem_wready) begin
               if (img_err) begin
                  ev_err = 1'b1;
                  st_d   = S_IDLE;
               end else if (addr == BHI) begin
                  st_d    = S_RUN;
                  run_set = 1'b1;
               end else begin
                  a_inc = 1'b1;
               end
            end
         end
         S_RUN: st_d = S_PWAIT;
         S_PWAIT: begin
            if (cpu_diag_done) begin
               if (cpu_diag_ok) begin
                  st_d = S_BOOT;
               end else begin
                  ev_wait = 1'b1;
                  ev_done = 1'b1;
                  st_d    = S_IDLE;
               end
            end
         end
         S_BOOT: begin
            ev_done = 1'b1;
            st_d    = S_IDLE;
         end
         default: st_d = S_IDLE;
      endcase
   end

   assign busy           = (st_q != S_IDLE);
   assign sys_reset      = (st_q == S_TRST) || (st_q == S_FRST);
   assign test_start     = (st_q == S_TGO);
   assign mem_we         = (st_q == S_CLR) || (st_q == S_LDIAG) || (st_q == S_LBOOT);
   assign mem_addr       = addr;
   assign mem_wdata      = (st_q == S_CLR) ? '0 : img_data;
   assign img_sel        = (st_q == S_LBOOT);
   assign run_mode       = run_q;
   assign cpu_start      = (st_q == S_RUN) || (st_q == S_BOOT);
   assign cpu_start_addr = (st_q == S_BOOT) ? ENTRY_B : ENTRY_D;

   // R1
   accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(load_req && sys_idle));

   // R3
   f9_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && err_code == EVT_TEST_FAIL) |-> $past(test_done && !test_pass));

   // R6
   f0_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && err_code == EVT_LOAD_FAIL) |-> $past(img_err && mem_we && mem_wready));

   // R8
   boot_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_start && cpu_start_addr == ENTRY_B) |-> $past(cpu_diag_done && cpu_diag_ok));

   // R9
   end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err_valid));

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !mem_wready) |=> (mem_we && $stable(mem_addr)));

endmodule

// File: tb/tb_boot_load_seq.sv
module tb_boot_load_seq;

   localparam int NT    = 4;
   localparam int DEPTH = 1024;

   logic        clk, rst_n;
   logic        load_req, sys_idle, test_done, test_pass;
   logic [15:0] test_status;
   logic        mem_wready;
   logic [31:0] img_data;
   logic        img_err, cpu_diag_done, cpu_diag_ok;
   logic        busy, sys_reset, test_start;
   logic [1:0]  test_idx;
   logic        mem_we;
   logic [11:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        img_sel, run_mode, cpu_start;
   logic [11:0] cpu_start_addr;
   logic        done, cpu_wait, err_valid;
   logic [7:0]  err_code;
   logic [15:0] err_status;

   boot_load_seq dut (.*);

   initial clk = 1'b0;
   always #5 clk = ~clk;

   function automatic logic [31:0] img_fn(input logic [11:0] a, input logic s);
      return {(s ? 16'hB007 : 16'hD1A6), 4'h0, a};
   endfunction

   logic        err_en;
   logic [11:0] err_at;
   assign img_data = img_fn(mem_addr, img_sel);
   assign img_err  = err_en && mem_we && (mem_addr == err_at);

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // behavioural reference model
   int          m_ph, m_idx, m_addr;
   bit          m_done, m_err, m_wait, m_run;
   logic [7:0]  m_code;
   logic [15:0] m_stat;
   logic [31:0] bmem [DEPTH];
   int          wr_cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_idx = 0; m_addr = 0;
         m_done = 0; m_err = 0; m_wait = 0; m_run = 0;
         m_code = 8'h00; m_stat = 16'h0;
      end else begin
         if (mem_we && mem_wready) begin
            bmem[mem_addr] = mem_wdata;
            wr_cnt++;
         end
         m_done = 0; m_err = 0; m_wait = 0;
         case (m_ph)
            0: if (load_req && sys_idle) begin m_ph = 1; m_idx = 0; m_run = 0; end
            1: m_ph = 2;
            2: m_ph = 3;
            3: if (test_done) begin
                  if (!test_pass) begin
                     m_err = 1; m_code = 8'hF9; m_stat = test_status; m_ph = 0;
                  end else if (m_idx == NT - 1) m_ph = 4;
                  else begin m_idx++; m_ph = 1; end
               end
            4: begin m_ph = 5; m_addr = 0; end
            5: if (mem_wready) begin
                  if (m_addr == DEPTH - 1) begin m_ph = 6; m_addr = 'h100; end
                  else m_addr++;
               end
            6: if (mem_wready) begin
                  if (img_err) begin m_err = 1; m_code = 8'hF0; m_stat = 0; m_ph = 0; end
                  else if (m_addr == 'h1FF) begin m_ph = 7; m_addr = 'h20; end
                  else m_addr++;
               end
            7: if (mem_wready) begin
                  if (img_err) begin m_err = 1; m_code = 8'hF0; m_stat = 0; m_ph = 0; end
                  else if (m_addr == 'h29) begin m_ph = 8; m_run = 1; end
                  else m_addr++;
               end
            8: m_ph = 9;
            9: if (cpu_diag_done) begin
                  if (cpu_diag_ok) m_ph = 10;
                  else begin m_wait = 1; m_done = 1; m_ph = 0; end
               end
            default: begin m_done = 1; m_ph = 0; end
         endcase
      end
   end

   // scenario observations and stub controls
   bit saw_done, saw_err, saw_wait, saw_boot;
   int n_rst, n_cpu_start, n_stall;
   int fail_idx, t_lat, c_lat;
   bit stall, cpu_ok;

   initial begin
      int t_cnt, c_cnt, cur_idx, cyc;
      t_cnt = 0; c_cnt = 0; cur_idx = 0; cyc = 0;
      test_done = 0; test_pass = 0; test_status = 0;
      cpu_diag_done = 0; cpu_diag_ok = 0; mem_wready = 1;
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n) begin
            chk(busy == (m_ph != 0), "R9 busy", busy, m_ph != 0);
            chk(sys_reset == (m_ph == 1 || m_ph == 4), "R2 sys_reset", sys_reset, m_ph == 1 || m_ph == 4);
            chk(test_start == (m_ph == 2), "R2 test_start", test_start, m_ph == 2);
            if (test_start) chk(test_idx == m_idx[1:0], "R2 test_idx", test_idx, m_idx);
            chk(mem_we == (m_ph >= 5 && m_ph <= 7), "R4 mem_we", mem_we, m_ph >= 5 && m_ph <= 7);
            if (mem_we) begin
               chk(mem_addr == m_addr[11:0], "R10 mem_addr", mem_addr, m_addr);
               chk(mem_wdata == ((m_ph == 5) ? 32'h0 : img_fn(m_addr[11:0], m_ph == 7)),
                   "R5 mem_wdata", mem_wdata, (m_ph == 5) ? 32'h0 : img_fn(m_addr[11:0], m_ph == 7));
               chk(img_sel == (m_ph == 7), "R5 img_sel", img_sel, m_ph == 7);
            end
            chk(cpu_start == (m_ph == 8 || m_ph == 10), "R7 cpu_start", cpu_start, m_ph == 8 || m_ph == 10);
            if (cpu_start) chk(cpu_start_addr == ((m_ph == 10) ? 12'h026 : 12'h160),
                               "R8 cpu_start_addr", cpu_start_addr, (m_ph == 10) ? 12'h026 : 12'h160);
            chk(run_mode == m_run, "R7 run_mode", run_mode, m_run);
            chk(done == m_done, "R9 done", done, m_done);
            chk(err_valid == m_err, "R9 err_valid", err_valid, m_err);
            chk(cpu_wait == m_wait, "R8 cpu_wait", cpu_wait, m_wait);
            chk(err_code == m_code, "R3 err_code", err_code, m_code);
            chk(err_status == m_stat, "R3 err_status", err_status, m_stat);
            if (done) saw_done = 1;
            if (err_valid) saw_err = 1;
            if (cpu_wait) saw_wait = 1;
            if (cpu_start && cpu_start_addr == 12'h026) saw_boot = 1;
            if (cpu_start) n_cpu_start++;
            if (sys_reset) n_rst++;
            if (mem_we && !mem_wready) n_stall++;
         end
         // stubs
         test_done = 0;
         if (t_cnt > 0) begin
            t_cnt--;
            if (t_cnt == 0) begin
               test_done   = 1;
               test_pass   = (cur_idx != fail_idx);
               test_status = 16'hA500 | 16'(cur_idx);
            end
         end
         if (test_start) begin t_cnt = t_lat; cur_idx = int'(test_idx); end
         cpu_diag_done = 0;
         if (c_cnt > 0) begin
            c_cnt--;
            if (c_cnt == 0) begin cpu_diag_done = 1; cpu_diag_ok = cpu_ok; end
         end
         if (cpu_start && cpu_start_addr == 12'h160) c_cnt = c_lat;
         mem_wready = !stall || (cyc % 3 != 0);
      end
   end

   task automatic do_run();
      for (int i = 0; i < DEPTH; i++) bmem[i] = 32'hDEADBEEF;
      saw_done = 0; saw_err = 0; saw_wait = 0; saw_boot = 0;
      n_rst = 0; n_cpu_start = 0; n_stall = 0; wr_cnt = 0;
      @(negedge clk); load_req = 1;
      @(negedge clk); load_req = 0;
      for (int k = 0; k < 8000 && !(saw_done || saw_err); k++) @(negedge clk);
      chk(saw_done || saw_err, "R9 flow end", 0, 1);
      repeat (2) @(negedge clk);
   endtask

   task automatic check_image();
      int bad_clr, bad_d, bad_b;
      bad_clr = 0; bad_d = 0; bad_b = 0;
      for (int a = 0; a < DEPTH; a++) begin
         if (a >= 'h100 && a <= 'h1FF) begin
            if (bmem[a] != img_fn(12'(a), 1'b0)) bad_d++;
         end else if (a >= 'h20 && a <= 'h29) begin
            if (bmem[a] != img_fn(12'(a), 1'b1)) bad_b++;
         end else if (bmem[a] != 32'h0) bad_clr++;
      end
      chk(bad_clr == 0, "R4 cleared words", bad_clr, 0);
      chk(bad_d == 0, "R5 diagnostic window", bad_d, 0);
      chk(bad_b == 0, "R5 bootstrap window", bad_b, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 0; load_req = 0; sys_idle = 1; err_en = 0; err_at = 0;
      fail_idx = -1; t_lat = 2; c_lat = 4; stall = 0; cpu_ok = 1; wr_cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(busy == 0, "R9 reset busy", busy, 0);
      chk(run_mode == 0, "R7 reset run_mode", run_mode, 0);
      chk(err_valid == 0 && done == 0, "R9 reset pulses", err_valid | done, 0);

      // R1: command while system not idle
      n_rst = 0; wr_cnt = 0;
      sys_idle = 0; load_req = 1;
      repeat (6) @(negedge clk);
      chk(busy == 0, "R1 ignored busy", busy, 0);
      chk(n_rst == 0 && wr_cnt == 0, "R1 ignored activity", n_rst + wr_cnt, 0);
      load_req = 0; sys_idle = 1;

      // full pass
      do_run();
      chk(saw_done && !saw_err, "R8 done", saw_done, 1);
      chk(saw_boot, "R8 bootstrap start", saw_boot, 1);
      chk(n_rst == NT + 1, "R2 reset count", n_rst, NT + 1);
      chk(wr_cnt == DEPTH + 256 + 10, "R4 write count", wr_cnt, DEPTH + 266);
      chk(run_mode == 1, "R7 run_mode held", run_mode, 1);
      check_image();

      // test 2 fails
      fail_idx = 2;
      do_run();
      chk(saw_err && err_code == 8'hF9, "R3 code", err_code, 8'hF9);
      chk(err_status == 16'hA502, "R3 status", err_status, 16'hA502);
      chk(wr_cnt == 0, "R3 no writes", wr_cnt, 0);
      chk(n_rst == 3, "R2 resets before failure", n_rst, 3);
      fail_idx = -1;

      // load fault at 0x105
      err_en = 1; err_at = 12'h105;
      do_run();
      chk(saw_err && err_code == 8'hF0, "R6 code", err_code, 8'hF0);
      chk(wr_cnt == DEPTH + 6, "R6 write count", wr_cnt, DEPTH + 6);
      chk(n_cpu_start == 0, "R6 no start", n_cpu_start, 0);
      chk(run_mode == 0, "R7 run_mode cleared", run_mode, 0);
      err_en = 0;

      // ready stalls, diagnostic program failure
      stall = 1; cpu_ok = 0;
      do_run();
      chk(saw_wait && saw_done, "R8 wait ending", saw_wait, 1);
      chk(!saw_boot, "R8 no bootstrap start", saw_boot, 0);
      chk(n_stall > 0, "R10 stalls seen", n_stall, 1);
      check_image();

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule